// File: doc/BRIEF.md
# Capacitive Key Touch Qualifier with Reference Tracking

This block turns per-key signal samples from a capacitive front end into a debounced key-status vector. On every cycle in which `sample_valid` is high, it takes one signal value for each of up to sixteen keys and measures how far the value has fallen below that key's stored reference level. A key becomes touched once the fall has reached the key's threshold on a fixed number of samples in a row. It is released after the same number of samples in a row that no longer meet that condition.

While a key is untouched, its reference follows slow changes in the signal. A programmable number of samples separates each one-count step, and the downward and upward directions have independent periods. While a key is touched, its reference is frozen. A touch that lasts longer than a programmable hold limit makes the key recalibrate, so that a key left covered works normally again. A host calibrate request recalibrates every key. Keys can be placed in suppression groups in which only one key may be touched at a time, and keys marked as slider members are exempt from this rule among themselves.

Top module: `touch_detect`

## Requirements
- R1: During reset `key_status` and `recal_pulse` are zero and every key is marked as needing calibration. The first valid sample after reset loads each enabled key's reference with its sample and sets that key's `recal_pulse` bit for one cycle.
- R2: A key's candidate condition is `reference - sample >= threshold`, with the comparison inclusive. Its status bit sets on the DI-th consecutive valid sample (DI=3 by default) that meets the condition, and clears on the DI-th consecutive valid sample that does not. Outputs change only on the clock edge that takes a valid sample.
- R3: A key whose `key_en` bit is 0 never reports touch and never pulses recalibrate. Its reference follows its sample directly.
- R4: While a key is not touched and its sample is below its reference, the reference drops by one count every `fall_period` such samples in a row. A period of 0 disables downward tracking.
- R5: While a key is not touched and its sample is above its reference, the reference rises by one count every `rise_period` such samples in a row. A period of 0 disables upward tracking.
- R6: A touched key's reference does not change, except through recalibration.
- R7: When `hold_limit` is nonzero, the hold_limit-th valid sample after a key's status set recalibrates the key: the reference is loaded with the sample, the status is cleared and `recal_pulse` is set for that key. A `hold_limit` of 0 disables this timeout.
- R8: A one-cycle `cal_req` pulse recalibrates every enabled key on the next valid sample, as in R1.
- R9: Within a nonzero group (2-bit field per key in `key_grp`, bits [2k+1:2k] for key k), a key cannot set while another key of the group is touched. The key already touched keeps the group. When several keys qualify on the same sample, the lowest index wins. Group 0 applies no suppression.
- R10: Two keys that both have their `slider_keys` bit set do not suppress each other, even in the same group. Each of them still suppresses, and is suppressed by, non-slider keys of that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Samples on `samples` are valid this cycle |
| samples | input | NK*SW | Signal value of key k at bits [k*SW +: SW] |
| key_en | input | NK | Per-key enable (0 means burst length zero, key off) |
| key_thr | input | NK*TW | Threshold of key k at bits [k*TW +: TW] |
| key_grp | input | 2*NK | Suppression group of key k at bits [2k +: 2] |
| slider_keys | input | NK | Per-key slider membership |
| fall_period | input | DW | Samples per downward reference step, 0 = off |
| rise_period | input | DW | Samples per upward reference step, 0 = off |
| hold_limit | input | RW | Samples of continuous touch before forced recalibration, 0 = never |
| cal_req | input | 1 | Host calibrate request |
| key_status | output | NK | Debounced touch status per key |
| recal_pulse | output | NK | One-cycle per-key recalibration indication |

## Verification
Keys are pressed with short runs that stop one sample short of the debounce count and with full runs. Thresholds are hit exactly and missed by one count, which separates an inclusive comparison from an exclusive one. Long offsets are applied with each drift period set, and detection is probed afterwards to reveal the direction and the gating of reference tracking: a key that should have drifted stays quiet, and a key held in detection must stay detected near its original level. Group tests press keys one after another and together, in plain groups, group 0 and slider groups, which distinguishes first-holder priority, lowest-index priority and the slider exemption.

// File: rtl/touch_detect.sv
module touch_detect #(
  parameter int NK = 16,
  parameter int SW = 12,
  parameter int TW = 8,
  parameter int DW = 8,
  parameter int RW = 16,
  parameter int DI = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_valid,
  input  logic [NK*SW-1:0] samples,
  input  logic [NK-1:0]    key_en,
  input  logic [NK*TW-1:0] key_thr,
  input  logic [2*NK-1:0]  key_grp,
  input  logic [NK-1:0]    slider_keys,
  input  logic [DW-1:0]    fall_period,
  input  logic [DW-1:0]    rise_period,
  input  logic [RW-1:0]    hold_limit,
  input  logic             cal_req,
  output logic [NK-1:0]    key_status,
  output logic [NK-1:0]    recal_pulse
);
  localparam int CW = $clog2(DI + 1);
  localparam int EW = SW + 1;
  localparam int PW = DW + 1;
  localparam int HW = RW + 1;
  localparam logic [CW-1:0] LAST = CW'(DI - 1);

  logic [SW-1:0] smp [NK];
  logic [TW-1:0] thr [NK];
  logic [1:0]    grp [NK];
  logic [SW-1:0] ref_q [NK];
  logic [CW-1:0] dcnt [NK];
  logic [DW-1:0] ncnt [NK];
  logic [DW-1:0] pcnt [NK];
  logic [RW-1:0] tmr [NK];
  logic [NK-1:0] status, needcal, recal;
  logic [NK-1:0] cand, want, held_blk, early, blk, tout;

  for (genvar g = 0; g < NK; g++) begin : g_unpack
    assign smp[g] = samples[g*SW +: SW];
    assign thr[g] = key_thr[g*TW +: TW];
    assign grp[g] = key_grp[2*g +: 2];
  end

  assign key_status  = status;
  assign recal_pulse = recal;

  function automatic logic clash(input logic [1:0] ga, input logic [1:0] gb,
                                 input logic sa, input logic sb);
    return (ga != 2'd0) && (ga == gb) && !(sa && sb);
  endfunction

  always_comb begin
    for (int i = 0; i < NK; i++) begin
      cand[i] = key_en[i] && (ref_q[i] >= smp[i]) &&
                ((EW'(ref_q[i]) - EW'(smp[i])) >= EW'(thr[i]));
      want[i] = key_en[i] && !needcal[i] && !status[i] && cand[i] && (dcnt[i] == LAST);
      tout[i] = status[i] && (hold_limit != '0) &&
                ((HW'(tmr[i]) + HW'(1)) == HW'(hold_limit));
    end
  end

  always_comb begin
    for (int i = 0; i < NK; i++) begin
      held_blk[i] = 1'b0;
      for (int j = 0; j < NK; j++)
        if (j != i && status[j] && clash(grp[i], grp[j], slider_keys[i], slider_keys[j]))
          held_blk[i] = 1'b1;
    end
    early = want & ~held_blk;
    for (int i = 0; i < NK; i++) begin
      blk[i] = held_blk[i];
      for (int j = 0; j < NK; j++)
        if (j < i && early[j] && clash(grp[i], grp[j], slider_keys[i], slider_keys[j]))
          blk[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status  <= '0;
      recal   <= '0;
      needcal <= '1;
      for (int i = 0; i < NK; i++) begin
        ref_q[i] <= '0;
        dcnt[i]  <= '0;
        ncnt[i]  <= '0;
        pcnt[i]  <= '0;
        tmr[i]   <= '0;
      end
    end else begin
      recal <= '0;
      if (sample_valid) begin
        for (int i = 0; i < NK; i++) begin
          if (!key_en[i]) begin
            ref_q[i]   <= smp[i];
            status[i]  <= 1'b0;
            needcal[i] <= 1'b0;
            dcnt[i] <= '0;
            ncnt[i] <= '0;
            pcnt[i] <= '0;
            tmr[i]  <= '0;
          end else if (needcal[i] || tout[i]) begin
            ref_q[i]   <= smp[i];
            status[i]  <= 1'b0;
            needcal[i] <= 1'b0;
            recal[i]   <= 1'b1;
            dcnt[i] <= '0;
            ncnt[i] <= '0;
            pcnt[i] <= '0;
            tmr[i]  <= '0;
          end else if (status[i]) begin
            ncnt[i] <= '0;
            pcnt[i] <= '0;
            tmr[i]  <= tmr[i] + RW'(1);
            if (cand[i]) dcnt[i] <= '0;
            else if (dcnt[i] == LAST) begin
              status[i] <= 1'b0;
              dcnt[i]   <= '0;
              tmr[i]    <= '0;
            end else dcnt[i] <= dcnt[i] + CW'(1);
          end else begin
            tmr[i] <= '0;
            if (!cand[i]) dcnt[i] <= '0;
            else if (dcnt[i] != LAST) dcnt[i] <= dcnt[i] + CW'(1);
            else if (!blk[i]) begin
              status[i] <= 1'b1;
              dcnt[i]   <= '0;
            end
            if (smp[i] < ref_q[i]) begin
              pcnt[i] <= '0;
              if (fall_period != '0) begin
                if ((PW'(ncnt[i]) + PW'(1)) >= PW'(fall_period)) begin
                  ref_q[i] <= ref_q[i] - SW'(1);
                  ncnt[i]  <= '0;
                end else ncnt[i] <= ncnt[i] + DW'(1);
              end
            end else if (smp[i] > ref_q[i]) begin
              ncnt[i] <= '0;
              if (rise_period != '0) begin
                if ((PW'(pcnt[i]) + PW'(1)) >= PW'(rise_period)) begin
                  ref_q[i] <= ref_q[i] + SW'(1);
                  pcnt[i]  <= '0;
                end else pcnt[i] <= pcnt[i] + DW'(1);
              end
            end else begin
              ncnt[i] <= '0;
              pcnt[i] <= '0;
            end
          end
        end
      end
      if (cal_req) needcal <= '1;
    end
  end

  // R2
  status_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> $stable(key_status));

  // R7
  recal_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (recal_pulse != '0) |-> $past(sample_valid));

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> ((key_status & ~$past(key_en)) == '0) && ((recal_pulse & ~$past(key_en)) == '0));

  for (genvar g = 0; g < NK; g++) begin : g_chk
    // R6
    frozen_ref_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(status[g]) && $past(key_en[g]) && !recal[g]) |-> (ref_q[g] == $past(ref_q[g])));
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (key_status == '0) && (recal_pulse == '0));
endmodule

// File: tb/test_touch_detect.sv
module test_touch_detect;
  localparam int NK = 16, SW = 12, TW = 8, DW = 8, RW = 16, DI = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_valid = 1'b0;
  logic cal_req = 1'b0;
  logic [NK*SW-1:0] samples;
  logic [NK-1:0] key_en = 16'hFFFD;
  logic [NK*TW-1:0] key_thr;
  logic [2*NK-1:0] key_grp;
  logic [NK-1:0] slider_keys = '0;
  logic [DW-1:0] fall_period = '0;
  logic [DW-1:0] rise_period = '0;
  logic [RW-1:0] hold_limit = '0;
  logic [NK-1:0] key_status, recal_pulse;

  int smp [NK];
  int thr_i [NK];
  int grp_i [NK];
  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  int rf [NK], dc [NK], nc [NK], pc [NK], tm [NK];
  bit [NK-1:0] st_m, rc_m, nd_m;

  always #10 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NK; k++) begin
      samples[k*SW +: SW] = SW'(smp[k]);
      key_thr[k*TW +: TW] = TW'(thr_i[k]);
      key_grp[2*k +: 2]   = 2'(grp_i[k]);
    end
  end

  touch_detect #(.NK(NK), .SW(SW), .TW(TW), .DW(DW), .RW(RW), .DI(DI)) i_touch_detect (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .samples(samples),
    .key_en(key_en), .key_thr(key_thr), .key_grp(key_grp), .slider_keys(slider_keys),
    .fall_period(fall_period), .rise_period(rise_period), .hold_limit(hold_limit),
    .cal_req(cal_req), .key_status(key_status), .recal_pulse(recal_pulse));

  function automatic bit conflicts(int a, int b);
    return grp_i[a] != 0 && grp_i[a] == grp_i[b] && !(slider_keys[a] && slider_keys[b]);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      st_m = '0; rc_m = '0; nd_m = '1;
      for (int k = 0; k < NK; k++) begin rf[k] = 0; dc[k] = 0; nc[k] = 0; pc[k] = 0; tm[k] = 0; end
    end else begin
      rc_m = '0;
      if (sample_valid) begin
        bit [NK-1:0] cd, wn, hbm, erl, bk;
        for (int k = 0; k < NK; k++) begin
          cd[k] = key_en[k] && (rf[k] - smp[k] >= thr_i[k]);
          wn[k] = key_en[k] && !nd_m[k] && !st_m[k] && cd[k] && dc[k] == DI - 1;
        end
        for (int k = 0; k < NK; k++) begin
          hbm[k] = 0;
          for (int j = 0; j < NK; j++) if (j != k && st_m[j] && conflicts(k, j)) hbm[k] = 1;
        end
        erl = wn & ~hbm;
        for (int k = 0; k < NK; k++) begin
          bk[k] = hbm[k];
          for (int j = 0; j < k; j++) if (erl[j] && conflicts(k, j)) bk[k] = 1;
        end
        for (int k = 0; k < NK; k++) begin
          bit timeout;
          timeout = st_m[k] && hold_limit != 0 && tm[k] + 1 == int'(hold_limit);
          if (!key_en[k]) begin
            rf[k] = smp[k]; st_m[k] = 0; nd_m[k] = 0; dc[k] = 0; nc[k] = 0; pc[k] = 0; tm[k] = 0;
          end else if (nd_m[k] || timeout) begin
            rf[k] = smp[k]; st_m[k] = 0; nd_m[k] = 0; rc_m[k] = 1;
            dc[k] = 0; nc[k] = 0; pc[k] = 0; tm[k] = 0;
          end else if (st_m[k]) begin
            nc[k] = 0; pc[k] = 0; tm[k]++;
            if (cd[k]) dc[k] = 0;
            else if (dc[k] == DI - 1) begin st_m[k] = 0; dc[k] = 0; tm[k] = 0; end
            else dc[k]++;
          end else begin
            int s;
            s = smp[k];
            tm[k] = 0;
            if (!cd[k]) dc[k] = 0;
            else if (dc[k] != DI - 1) dc[k]++;
            else if (!bk[k]) begin st_m[k] = 1; dc[k] = 0; end
            if (s < rf[k]) begin
              pc[k] = 0;
              if (fall_period != 0) begin
                if (nc[k] + 1 >= int'(fall_period)) begin rf[k]--; nc[k] = 0; end else nc[k]++;
              end
            end else if (s > rf[k]) begin
              nc[k] = 0;
              if (rise_period != 0) begin
                if (pc[k] + 1 >= int'(rise_period)) begin rf[k]++; pc[k] = 0; end else pc[k]++;
              end
            end else begin nc[k] = 0; pc[k] = 0; end
          end
        end
      end
      if (cal_req) nd_m = '1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      checks++;
      if (key_status !== st_m || recal_pulse !== rc_m) begin
        errors++;
        $display("FAIL %s model compare: status=%h recal=%h expected status=%h recal=%h",
                 cur_req, key_status, recal_pulse, st_m, rc_m);
      end
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, bit ok, logic [NK-1:0] act, logic [NK-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic samp(int n);
    for (int r = 0; r < n; r++) begin
      @(negedge clk); sample_valid = 1'b1;
      @(negedge clk); sample_valid = 1'b0;
    end
  endtask

  task automatic bit_is(string req, int k, bit v);
    chk(req, key_status[k] == v, NK'(key_status[k]), NK'(v));
  endtask

  initial begin
    for (int k = 0; k < NK; k++) begin smp[k] = 1000; thr_i[k] = 20; grp_i[k] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", key_status == '0 && recal_pulse == '0, key_status, '0);
    samp(1);
    chk("R1", recal_pulse == 16'hFFFD, recal_pulse, 16'hFFFD);
    samp(1);
    chk("R1", recal_pulse == '0, recal_pulse, '0);

    cur_req = "R2";
    smp[0] = 970; samp(2); bit_is("R2", 0, 0);
    samp(1); bit_is("R2", 0, 1);
    smp[0] = 1000; samp(2); bit_is("R2", 0, 1);
    samp(1); bit_is("R2", 0, 0);
    smp[0] = 980; samp(3); bit_is("R2", 0, 1);
    smp[0] = 981; samp(3); bit_is("R2", 0, 0);
    smp[0] = 1000; samp(1);

    cur_req = "R3";
    smp[1] = 500; samp(5); bit_is("R3", 1, 0);
    chk("R3", recal_pulse[1] == 1'b0, recal_pulse, '0);
    smp[1] = 1000;

    cur_req = "R4";
    fall_period = 8'd2; smp[2] = 990; samp(30);
    smp[2] = 975; samp(4); bit_is("R4", 2, 0);
    fall_period = 8'd0; smp[2] = 988; samp(1);

    cur_req = "R5";
    rise_period = 8'd1; smp[3] = 1030; samp(40);
    rise_period = 8'd0; smp[3] = 1005; samp(3); bit_is("R5", 3, 1);
    smp[3] = 1030; samp(3); bit_is("R5", 3, 0);

    cur_req = "R6";
    fall_period = 8'd1; smp[4] = 900; samp(3); bit_is("R6", 4, 1);
    samp(40);
    smp[4] = 975; samp(5); bit_is("R6", 4, 1);
    smp[4] = 1000; samp(3); bit_is("R6", 4, 0);
    fall_period = 8'd0;

    cur_req = "R7";
    hold_limit = 16'd5; smp[5] = 900; samp(3); bit_is("R7", 5, 1);
    samp(4);
    chk("R7", recal_pulse[5] == 1'b0 && key_status[5], recal_pulse, '0);
    samp(1);
    chk("R7", recal_pulse[5] == 1'b1 && !key_status[5], recal_pulse, NK'(1) << 5);
    samp(4); bit_is("R7", 5, 0);
    hold_limit = 16'd0; smp[5] = 1000;

    cur_req = "R8";
    @(negedge clk); cal_req = 1'b1;
    @(negedge clk); cal_req = 1'b0;
    samp(1);
    chk("R8", recal_pulse == 16'hFFFD, recal_pulse, 16'hFFFD);

    cur_req = "R9";
    grp_i[6] = 1; grp_i[7] = 1;
    smp[7] = 900; samp(3); bit_is("R9", 7, 1);
    smp[6] = 900; samp(3); bit_is("R9", 6, 0);
    smp[7] = 1000; samp(3); bit_is("R9", 7, 0); bit_is("R9", 6, 0);
    samp(1); bit_is("R9", 6, 1);
    smp[6] = 1000; samp(3); bit_is("R9", 6, 0);
    smp[6] = 900; smp[7] = 900; samp(3);
    bit_is("R9", 6, 1); bit_is("R9", 7, 0);
    smp[6] = 1000; smp[7] = 1000; samp(4);
    smp[8] = 900; smp[9] = 900; samp(3);
    bit_is("R9", 8, 1); bit_is("R9", 9, 1);
    smp[8] = 1000; smp[9] = 1000; samp(3);

    cur_req = "R10";
    grp_i[10] = 2; grp_i[11] = 2; grp_i[12] = 2; slider_keys = 16'h0C00;
    smp[10] = 900; smp[11] = 900; samp(3);
    bit_is("R10", 10, 1); bit_is("R10", 11, 1);
    smp[12] = 900; samp(3); bit_is("R10", 12, 0);
    smp[10] = 1000; smp[11] = 1000; smp[12] = 1000; samp(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule